// File: doc/BRIEF.md
# Event-Selectable Performance Counter Unit

This unit counts microarchitectural events for a small processor core. The core drives single-cycle event pulses (cache misses, TLB misses, branches, retired instructions, data-cache accesses, software PC changes) and level-type stall conditions into the unit. It also drives a count of half cache lines written back in the current cycle. Four 32-bit counters each choose one of these sources through an 8-bit code. All four codes sit in one shared select register.

Software reaches the unit through a single-cycle register port. That port carries the select register, the four counters, a control word (global enable and a clear-all strobe) and a set of sticky overflow flags. The unit decides how much each counter advances in each cycle:
- Stall levels can be counted per cycle or once per contiguous run.
- Write-backs add one per half line.
- PC changes caused by entry to a vector are filtered out.
- Reserved codes add nothing.

Top module: `perf_counter_unit`

## Requirements
- R1: Each of the four counters counts the event chosen by its own 8-bit select field, independently of the others. Field n occupies bits [8n+7:8n] of the select register at address 2, which reads back as written.
- R2: Codes 0x00 (instruction-cache fetch), 0x03 (instruction TLB miss), 0x04 (data TLB miss), 0x05 (branch), 0x06 (branch mispredict), 0x07 (instruction executed), 0x0A (data-cache access) and 0x0B (data-cache miss) each add 1 in every cycle in which their pulse input is high.
- R3: Codes 0x01 (fetch stall), 0x02 (dependency stall) and 0x08 (buffer-full stall) add 1 in every cycle in which the stall level is high.
- R4: Code 0x09 adds 1 once per contiguous run of the buffer-full stall level, in the first cycle of the run.
- R5: Code 0x0C adds the value of the 2-bit half-line write-back input (0, 1 or 2) in that cycle.
- R6: Code 0x0D adds 1 for a PC change only when the vector-entry qualifier is low in the same cycle.
- R7: Codes 0x0E through 0xFF are reserved, and a counter selecting one of them never changes by counting.
- R8: Bit 0 of the control register (address 0) is the global enable. While it is 0, no counter advances.
- R9: A write to address 0 with bit 1 set clears all four counters in that cycle, overriding any increment.
- R10: A write to counter n (address 4+n) loads the written value, overriding any increment in the same cycle.
- R11: An increment that carries out of bit 31 of counter n sets sticky flag n (address 1, bit n). Writing 1 to bit n clears it, and a carry in the same cycle wins over the clear.
- R12: After reset, every counter, flag, select field and the enable are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_icache_fetch | input | 1 | Instruction-cache miss fetch pulse |
| ev_fetch_stall | input | 1 | Instruction supply stall level |
| ev_dep_stall | input | 1 | Data-dependency stall level |
| ev_itlb_miss | input | 1 | Instruction TLB miss pulse |
| ev_dtlb_miss | input | 1 | Data TLB miss pulse |
| ev_branch | input | 1 | Branch executed pulse |
| ev_branch_miss | input | 1 | Branch mispredicted pulse |
| ev_instr | input | 1 | Instruction executed pulse |
| ev_buf_stall | input | 1 | Buffer-full stall level |
| ev_dc_access | input | 1 | Data-cache access pulse |
| ev_dc_miss | input | 1 | Data-cache miss pulse |
| ev_wb_halves | input | 2 | Half lines written back this cycle (0 to 2) |
| ev_pc_change | input | 1 | PC changed pulse |
| ev_pc_vector | input | 1 | PC change is a vector entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
A wrong select decode or a wrong shaping of a source shows up as a counter value off by one or more when it is read back in the cycle after the stimulus. Such a fault also hides at a counter that is never read. A lost edge-detect state turns a single run count into a count per cycle. That error grows with run length, so multi-cycle runs expose it at once. Overflow and priority faults appear only at the wrap boundary or under collisions between a write and an increment, so those cases are forced directly by preloading counters near all ones.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned SEL_W = 8;

  typedef enum logic [7:0] {
    EV_IC_FETCH   = 8'h00,
    EV_FETCH_STL  = 8'h01,
    EV_DEP_STL    = 8'h02,
    EV_ITLB_MISS  = 8'h03,
    EV_DTLB_MISS  = 8'h04,
    EV_BRANCH     = 8'h05,
    EV_BR_MISS    = 8'h06,
    EV_INSTR      = 8'h07,
    EV_BUF_CYCLE  = 8'h08,
    EV_BUF_RUN    = 8'h09,
    EV_DC_ACCESS  = 8'h0A,
    EV_DC_MISS    = 8'h0B,
    EV_WRITEBACK  = 8'h0C,
    EV_PC_SW      = 8'h0D
  } pcu_code_e;

  // Conditioned events, one cycle wide, after edge detect and filtering.
  typedef struct packed {
    logic       ic_fetch;
    logic       fetch_stall;
    logic       dep_stall;
    logic       itlb_miss;
    logic       dtlb_miss;
    logic       branch;
    logic       branch_miss;
    logic       instr;
    logic       buf_cycle;
    logic       buf_run;
    logic       dc_access;
    logic       dc_miss;
    logic [1:0] wb_halves;
    logic       pc_sw;
  } pcu_events_t;

  // Amount a counter selecting 'code' advances this cycle; reserved codes give 0.
  function automatic logic [1:0] event_amount(input logic [SEL_W-1:0] code,
                                               input pcu_events_t ev);
    logic [1:0] amt;
    case (code)
      EV_IC_FETCH:  amt = {1'b0, ev.ic_fetch};
      EV_FETCH_STL: amt = {1'b0, ev.fetch_stall};
      EV_DEP_STL:   amt = {1'b0, ev.dep_stall};
      EV_ITLB_MISS: amt = {1'b0, ev.itlb_miss};
      EV_DTLB_MISS: amt = {1'b0, ev.dtlb_miss};
      EV_BRANCH:    amt = {1'b0, ev.branch};
      EV_BR_MISS:   amt = {1'b0, ev.branch_miss};
      EV_INSTR:     amt = {1'b0, ev.instr};
      EV_BUF_CYCLE: amt = {1'b0, ev.buf_cycle};
      EV_BUF_RUN:   amt = {1'b0, ev.buf_run};
      EV_DC_ACCESS: amt = {1'b0, ev.dc_access};
      EV_DC_MISS:   amt = {1'b0, ev.dc_miss};
      EV_WRITEBACK: amt = ev.wb_halves;
      EV_PC_SW:     amt = {1'b0, ev.pc_sw};
      default:      amt = 2'd0;
    endcase
    return amt;
  endfunction

endpackage

// File: rtl/pcu_event_shape.sv
module pcu_event_shape (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ic_fetch_i,
  input  logic                 fetch_stall_i,
  input  logic                 dep_stall_i,
  input  logic                 itlb_miss_i,
  input  logic                 dtlb_miss_i,
  input  logic                 branch_i,
  input  logic                 branch_miss_i,
  input  logic                 instr_i,
  input  logic                 buf_stall_i,
  input  logic                 dc_access_i,
  input  logic                 dc_miss_i,
  input  logic [1:0]           wb_halves_i,
  input  logic                 pc_change_i,
  input  logic                 pc_vector_i,
  output pcu_pkg::pcu_events_t ev_o
);

  logic buf_prev_q;
  logic buf_rise;
  logic pc_sw_change;

  always_ff @(posedge clk) begin
    if (!rst_n) buf_prev_q <= 1'b0;
    else        buf_prev_q <= buf_stall_i;
  end

  assign buf_rise     = buf_stall_i & ~buf_prev_q;
  assign pc_sw_change = pc_change_i & ~pc_vector_i;

  always_comb begin
    ev_o.ic_fetch    = ic_fetch_i;
    ev_o.fetch_stall = fetch_stall_i;
    ev_o.dep_stall   = dep_stall_i;
    ev_o.itlb_miss   = itlb_miss_i;
    ev_o.dtlb_miss   = dtlb_miss_i;
    ev_o.branch      = branch_i;
    ev_o.branch_miss = branch_miss_i;
    ev_o.instr       = instr_i;
    ev_o.buf_cycle   = buf_stall_i;
    ev_o.buf_run     = buf_rise;
    ev_o.dc_access   = dc_access_i;
    ev_o.dc_miss     = dc_miss_i;
    ev_o.wb_halves   = wb_halves_i;
    ev_o.pc_sw       = pc_sw_change;
  end

  // A run pulse can never occur in two consecutive cycles.
  assert_single_run_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rise |=> !buf_rise);

  // A held stall level yields no further run pulse.
  assert_run_needs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_stall_i && $past(buf_stall_i) |-> !ev_o.buf_run);

  // Vector entries never reach the software PC change event.
  assert_vector_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_vector_i |-> !ev_o.pc_sw);

endmodule

// File: rtl/pcu_counter_slice.sv
module pcu_counter_slice #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic [1:0]       amount_i,
  input  logic             clear_all_i,
  input  logic             wr_en_i,
  input  logic [CTR_W-1:0] wr_data_i,
  input  logic             ovf_clr_i,
  output logic [CTR_W-1:0] count_o,
  output logic             ovf_o
);

  // Sum with carry out; the carry marks a wrap through zero.
  function automatic logic [CTR_W:0] wrap_add(input logic [CTR_W-1:0] a,
                                              input logic [1:0] b);
    return {1'b0, a} + {{(CTR_W-1){1'b0}}, b};
  endfunction

  logic [CTR_W:0] sum;
  logic           step;
  logic           wrap_evt;

  assign sum      = wrap_add(count_o, amount_i);
  assign step     = enable_i && !wr_en_i && !clear_all_i;
  assign wrap_evt = step && sum[CTR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (wr_en_i) begin
      count_o <= wr_data_i;
    end else if (clear_all_i) begin
      count_o <= '0;
    end else if (enable_i) begin
      count_o <= sum[CTR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_o <= 1'b0;
    else if (wrap_evt)  ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i && !wr_en_i && !clear_all_i |=> $stable(count_o));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> count_o == $past(wr_data_i));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all_i && !wr_en_i |=> count_o == '0);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o);

  assert_flag_on_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_o && count_o < CTR_W'(3));

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter  int NUM_CTR = 4,
  parameter  int CTR_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_CTR) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_icache_fetch,
  input  logic              ev_fetch_stall,
  input  logic              ev_dep_stall,
  input  logic              ev_itlb_miss,
  input  logic              ev_dtlb_miss,
  input  logic              ev_branch,
  input  logic              ev_branch_miss,
  input  logic              ev_instr,
  input  logic              ev_buf_stall,
  input  logic              ev_dc_access,
  input  logic              ev_dc_miss,
  input  logic [1:0]        ev_wb_halves,
  input  logic              ev_pc_change,
  input  logic              ev_pc_vector,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTR_W-1:0]  reg_wdata,
  output logic [CTR_W-1:0]  reg_rdata
);
  import pcu_pkg::*;

  localparam int SEL_TOT  = NUM_CTR * SEL_W;
  localparam int CTR_BASE = 1 << $clog2(NUM_CTR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2);

  pcu_events_t          ev;
  logic                 enable_q;
  logic [SEL_TOT-1:0]   sel_q;
  logic                 clear_all;
  logic [NUM_CTR-1:0]   ovf;
  logic [CTR_W-1:0]     cnt [NUM_CTR];

  pcu_event_shape u_shape (
    .clk           (clk),
    .rst_n         (rst_n),
    .ic_fetch_i    (ev_icache_fetch),
    .fetch_stall_i (ev_fetch_stall),
    .dep_stall_i   (ev_dep_stall),
    .itlb_miss_i   (ev_itlb_miss),
    .dtlb_miss_i   (ev_dtlb_miss),
    .branch_i      (ev_branch),
    .branch_miss_i (ev_branch_miss),
    .instr_i       (ev_instr),
    .buf_stall_i   (ev_buf_stall),
    .dc_access_i   (ev_dc_access),
    .dc_miss_i     (ev_dc_miss),
    .wb_halves_i   (ev_wb_halves),
    .pc_change_i   (ev_pc_change),
    .pc_vector_i   (ev_pc_vector),
    .ev_o          (ev)
  );

  assign clear_all = reg_wr && (reg_addr == A_CTRL) && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      sel_q    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) enable_q <= reg_wdata[0];
      if (reg_addr == A_SEL)  sel_q    <= reg_wdata[SEL_TOT-1:0];
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic [SEL_W-1:0] code;
    logic [1:0]       amount;
    logic             wr_hit;
    logic             flag_clr;

    assign code     = sel_q[n*SEL_W +: SEL_W];
    assign amount   = event_amount(code, ev);
    assign wr_hit   = reg_wr && (reg_addr == ADDR_W'(CTR_BASE + n));
    assign flag_clr = reg_wr && (reg_addr == A_FLAG) && reg_wdata[n];

    pcu_counter_slice #(.CTR_W(CTR_W)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable_q),
      .amount_i    (amount),
      .clear_all_i (clear_all),
      .wr_en_i     (wr_hit),
      .wr_data_i   (reg_wdata),
      .ovf_clr_i   (flag_clr),
      .count_o     (cnt[n]),
      .ovf_o       (ovf[n])
    );

    assert_reserved_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      code > SEL_W'(8'h0D) && !wr_hit && !clear_all |=> $stable(cnt[n]));

    assert_amount_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      amount != 2'd3);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata[0] = enable_q;
    if (reg_addr == A_FLAG) reg_rdata[NUM_CTR-1:0] = ovf;
    if (reg_addr == A_SEL)  reg_rdata[SEL_TOT-1:0] = sel_q;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reg_addr == ADDR_W'(CTR_BASE + n)) reg_rdata = cnt[n];
    end
  end

endmodule

// File: tb/perf_counter_unit_tb.sv
module perf_counter_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_icache_fetch, ev_fetch_stall, ev_dep_stall, ev_itlb_miss;
  logic        ev_dtlb_miss, ev_branch, ev_branch_miss, ev_instr, ev_buf_stall;
  logic        ev_dc_access, ev_dc_miss, ev_pc_change, ev_pc_vector;
  logic [1:0]  ev_wb_halves;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int errors = 0;
  int total  = 0;

  always #5 clk = ~clk;

  perf_counter_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_icache_fetch(ev_icache_fetch), .ev_fetch_stall(ev_fetch_stall),
    .ev_dep_stall(ev_dep_stall), .ev_itlb_miss(ev_itlb_miss),
    .ev_dtlb_miss(ev_dtlb_miss), .ev_branch(ev_branch),
    .ev_branch_miss(ev_branch_miss), .ev_instr(ev_instr),
    .ev_buf_stall(ev_buf_stall), .ev_dc_access(ev_dc_access),
    .ev_dc_miss(ev_dc_miss), .ev_wb_halves(ev_wb_halves),
    .ev_pc_change(ev_pc_change), .ev_pc_vector(ev_pc_vector),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Pattern bits: 0 ic_fetch, 1 fetch_stall, 2 dep_stall, 3 itlb, 4 dtlb,
  // 5 branch, 6 br_miss, 7 instr, 8 buf_stall, 9 dc_access, 10 dc_miss,
  // 12:11 wb_halves, 13 pc_change, 14 pc_vector.
  // Entry: {code, pattern, expected increment}.
  localparam int NV = 20;
  localparam logic [24:0] VEC [NV] = '{
    {8'h00, 15'h0001, 2'd1}, {8'h01, 15'h0002, 2'd1},
    {8'h02, 15'h0004, 2'd1}, {8'h03, 15'h0008, 2'd1},
    {8'h04, 15'h0010, 2'd1}, {8'h05, 15'h0020, 2'd1},
    {8'h06, 15'h0040, 2'd1}, {8'h07, 15'h0080, 2'd1},
    {8'h08, 15'h0100, 2'd1}, {8'h09, 15'h0100, 2'd1},
    {8'h0A, 15'h0200, 2'd1}, {8'h0B, 15'h0400, 2'd1},
    {8'h0C, 15'h1000, 2'd2}, {8'h0C, 15'h0800, 2'd1},
    {8'h0D, 15'h2000, 2'd1}, {8'h0D, 15'h6000, 2'd0},
    {8'h07, 15'h6F7F, 2'd0}, {8'h10, 15'h6FFF, 2'd0},
    {8'hFF, 15'h6FFF, 2'd0}, {8'h0E, 15'h6FFF, 2'd0}
  };

  function automatic string tag_for(input logic [7:0] code);
    if (code > 8'h0D) return "R7";
    case (code)
      8'h01, 8'h02, 8'h08: return "R3";
      8'h09: return "R4";
      8'h0C: return "R5";
      8'h0D: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pat(input logic [14:0] p);
    ev_icache_fetch = p[0];  ev_fetch_stall = p[1];  ev_dep_stall = p[2];
    ev_itlb_miss    = p[3];  ev_dtlb_miss   = p[4];  ev_branch    = p[5];
    ev_branch_miss  = p[6];  ev_instr       = p[7];  ev_buf_stall = p[8];
    ev_dc_access    = p[9];  ev_dc_miss     = p[10]; ev_wb_halves = p[12:11];
    ev_pc_change    = p[13]; ev_pc_vector   = p[14];
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic run(input logic [14:0] p, input int cycles);
    set_pat(p);
    repeat (cycles) @(negedge clk);
    set_pat('0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_pat('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    rd_chk("R12 ctrl", 3'd0, 32'h0);
    rd_chk("R12 flags", 3'd1, 32'h0);
    rd_chk("R12 select", 3'd2, 32'h0);
    for (int n = 0; n < 4; n++) rd_chk("R12 counter", 3'(4 + n), 32'h0);

    // Vector table: all counters share the code under test.
    for (int i = 0; i < NV; i++) begin
      logic [7:0]  code;
      logic [14:0] pat;
      logic [1:0]  exp;
      {code, pat, exp} = VEC[i];
      wr(3'd2, {4{code}});
      wr(3'd0, 32'h3);
      run(pat, 1);
      for (int n = 0; n < 4; n++) rd_chk(tag_for(code), 3'(4 + n), {30'd0, exp});
    end

    // R8: disabled unit does not count
    wr(3'd2, {4{8'h07}});
    wr(3'd0, 32'h2);
    run(15'h0080, 3);
    rd_chk("R8 ctrl", 3'd0, 32'h0);
    for (int n = 0; n < 4; n++) rd_chk("R8 hold", 3'(4 + n), 32'h0);

    // R1: independent selects
    wr(3'd2, 32'h0B050A07);
    wr(3'd0, 32'h3);
    rd_chk("R1 select readback", 3'd2, 32'h0B050A07);
    run(15'h0280, 1);
    run(15'h00A0, 1);
    run(15'h0080, 1);
    rd_chk("R1 c0 instr", 3'd4, 32'd3);
    rd_chk("R1 c1 dc_access", 3'd5, 32'd1);
    rd_chk("R1 c2 branch", 3'd6, 32'd1);
    rd_chk("R1 c3 dc_miss", 3'd7, 32'd0);

    // R3/R4: cycles versus runs
    wr(3'd2, 32'h02010908);
    wr(3'd0, 32'h3);
    run(15'h0102, 4);
    run(15'h0100, 1);
    run(15'h0000, 2);
    run(15'h0100, 3);
    rd_chk("R3 buf cycles", 3'd4, 32'd8);
    rd_chk("R4 buf runs", 3'd5, 32'd2);
    rd_chk("R3 fetch stall", 3'd6, 32'd4);
    rd_chk("R3 dep idle", 3'd7, 32'd0);

    // R10: write beats increment
    wr(3'd2, {4{8'h07}});
    wr(3'd0, 32'h3);
    @(negedge clk);
    set_pat(15'h0080);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'd100;
    @(negedge clk);
    reg_wr = 1'b0; set_pat('0);
    rd_chk("R10 write wins", 3'd4, 32'd100);
    rd_chk("R10 neighbour counts", 3'd5, 32'd1);

    // R11/R5: wrap and sticky flag
    wr(3'd2, 32'h070C0707);
    wr(3'd4, 32'hFFFFFFFF);
    wr(3'd6, 32'hFFFFFFFE);
    run(15'h1080, 1);
    rd_chk("R11 wrap c0", 3'd4, 32'd0);
    rd_chk("R5 wrap by two c2", 3'd6, 32'd0);
    rd_chk("R11 flags set", 3'd1, 32'h5);
    run(15'h0080, 1);
    rd_chk("R11 sticky", 3'd1, 32'h5);
    rd_chk("R11 c0 after wrap", 3'd4, 32'd1);
    wr(3'd1, 32'h1);
    rd_chk("R11 clear one", 3'd1, 32'h4);
    wr(3'd4, 32'hFFFFFFFF);
    @(negedge clk);
    set_pat(15'h0080);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h5;
    @(negedge clk);
    reg_wr = 1'b0; set_pat('0);
    rd_chk("R11 set beats clear", 3'd1, 32'h1);

    // R9: clear all beats increment
    @(negedge clk);
    set_pat(15'h0080);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h3;
    @(negedge clk);
    reg_wr = 1'b0; set_pat('0);
    for (int n = 0; n < 4; n++) rd_chk("R9 clear all", 3'(4 + n), 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule